// File: doc/BRIEF.md
# Power-Failure Status and Sleep-Width Monitor

This block is a 16-bit configuration and status register with the monitoring logic behind it. It lives in the always-on well and runs entirely on the slow real-time clock. It samples the core power-good and processor-regulator power-good inputs on that clock. When either input falls while the platform is in a working state (S0 or S1), it latches a sticky failure flag. Each flag is cleared in its own way: one by writing a 1, one by writing a 0, and the core flag also clears when the platform reaches mechanical-off.

A second checker measures how long the deep-sleep signal stays asserted. It can be started in two ways: by the deep-sleep signal rising during S4/S5 entry, or by the resume-reset input being released on the way out of mechanical-off. If deep-sleep drops before a programmable minimum width has elapsed, the checker records a violation. The register also holds a rate code for a free-running software-SMI interval timer, which emits a one-clock pulse each period. A disable bit hands the deep-sleep pin over to other use.

Access is through a single write port (write enable plus a 16-bit word) and a registered read-back word. Two synchronous active-high resets apply. The RTC-well reset clears everything. The resume reset clears only the width-violation flag and the width timer.

Top module: `pwr_fail_monitor`

## Requirements
- R1: Register bits [1:0] select the SMI interval: code 0, 1, 2 and 3 give SMI_P0, SMI_P1, SMI_P2 and SMI_P3 clocks between pulses (defaults 49, 524, 1049 and 2097 ticks of 32.768 kHz). `smi_tick` is high for exactly one clock per period, and a new code takes effect at the next reload.
- R2: The rate code, the pin-disable bit (bit 2), the stretch-enable bit (bit 3) and the minimum-width code (bits [5:4]) keep their values while `rsm_rst` is asserted. Only `rtc_rst` returns them to 0.
- R3: Bit 8 (core power failure) sets when `core_pg` is sampled high and then low on the next clock while `pwr_state` is S0 (3'd0) or S1 (3'd1). A fall in any other state, such as S3 (3'd3), leaves the bit unchanged.
- R4: Bit 8 clears when software writes 1 to it, and whenever `pwr_state` is G3 (3'd7). Writing 0 to bit 8 leaves it unchanged.
- R5: Bit 9 (regulator failure) sets when `vrm_pg` falls while the state is S0 or S1 (a fall in S4 is ignored). It clears only when software writes 0 to it. Writing 1 leaves it unchanged.
- R6: The width timer starts on a rising `slp_deep` while the state is S4 (3'd4) or S5 (3'd5), and on the clock where `rsm_rst` is first seen low after being high. A rising `slp_deep` in S3 does not start it.
- R7: The minimum width is LIM = (code+1) × MINW_BASE clocks. Counting the start edge as edge 0, bit 10 (width violation) sets if `slp_deep` is sampled low on any of edges 1 to LIM. Holding it high through edge LIM sets nothing. The stretch-enable bit has no effect on this check.
- R8: Bit 10 clears when software writes 1 to it, and while `rsm_rst` is asserted.
- R9: With the pin-disable bit at 0, `pin_oe` is 1 and `pin_out` follows `slp_deep` one clock later. With the bit at 1, `pin_oe` and `pin_out` are both 0.
- R10: Bits 6, 7 and 15:11 always read 0 and ignore writes. After `rtc_rst` the whole word reads 0x0000. `rd_data` shows the register contents with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock |
| rtc_rst | input | 1 | RTC-well reset, synchronous, active high |
| rsm_rst | input | 1 | Resume-well reset, synchronous, active high |
| pwr_state | input | 3 | Encoded platform power state |
| core_pg | input | 1 | Core power-good |
| vrm_pg | input | 1 | Processor regulator power-good |
| slp_deep | input | 1 | Deep-sleep signal, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write word |
| rd_data | output | 16 | Registered read-back word |
| smi_tick | output | 1 | One-clock SMI interval pulse |
| pin_out | output | 1 | Deep-sleep pin value |
| pin_oe | output | 1 | Deep-sleep pin drive enable |

## Verification
The assertions check the following on every clock:
- a qualified power-good fall always sets its flag;
- mechanical-off always clears the core flag;
- the regulator flag never drops except on a 0 write;
- the configuration is untouched by the resume reset;
- the SMI pulse never lasts two clocks;
- the pin never drives while disabled;
- the reserved bits stay zero.

The exact interval for each rate code, the one-clock boundary between a violating and a passing sleep width, and the two different timer start events can be shown only by the bench's scenarios. Those scenarios also compare the register word against expected values.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int REG_W = 16;

  localparam logic [2:0] PS_S0 = 3'd0;
  localparam logic [2:0] PS_S1 = 3'd1;
  localparam logic [2:0] PS_S3 = 3'd3;
  localparam logic [2:0] PS_S4 = 3'd4;
  localparam logic [2:0] PS_S5 = 3'd5;
  localparam logic [2:0] PS_G3 = 3'd7;

  localparam int F_RATE    = 0;
  localparam int F_PIN_DIS = 2;
  localparam int F_STRETCH = 3;
  localparam int F_MINW    = 4;
  localparam int F_PWR     = 8;
  localparam int F_VRM     = 9;
  localparam int F_VIOL    = 10;

  localparam logic [REG_W-1:0] RSV_MASK = 16'hF8C0;

  typedef struct packed {
    logic [1:0] minw;
    logic       stretch;
    logic       pin_dis;
    logic [1:0] rate;
  } cfg_t;
endpackage

// File: rtl/pfm_pg_mon.sv
module pfm_pg_mon
  import pfm_pkg::*;
(
  input  logic       clk,
  input  logic       rtc_rst,
  input  logic [2:0] pwr_state,
  input  logic       core_pg,
  input  logic       vrm_pg,
  output logic       pwr_set,
  output logic       vrm_set,
  output logic       in_g3
);
  logic core_q;
  logic vrm_q;
  logic working;

  always_ff @(posedge clk) begin
    if (rtc_rst) begin
      core_q <= 1'b0;
      vrm_q  <= 1'b0;
    end else begin
      core_q <= core_pg;
      vrm_q  <= vrm_pg;
    end
  end

  always_comb begin
    working = (pwr_state == PS_S0) || (pwr_state == PS_S1);
    pwr_set = working && core_q && !core_pg;
    vrm_set = working && vrm_q && !vrm_pg;
    in_g3   = (pwr_state == PS_G3);
  end
endmodule

// File: rtl/pfm_smi_tmr.sv
module pfm_smi_tmr #(
  parameter int unsigned SMI_P0 = 49,
  parameter int unsigned SMI_P1 = 524,
  parameter int unsigned SMI_P2 = 1049,
  parameter int unsigned SMI_P3 = 2097
) (
  input  logic       clk,
  input  logic       rtc_rst,
  input  logic [1:0] rate,
  output logic       smi_tick
);
  localparam int unsigned PM01 = (SMI_P0 > SMI_P1) ? SMI_P0 : SMI_P1;
  localparam int unsigned PM23 = (SMI_P2 > SMI_P3) ? SMI_P2 : SMI_P3;
  localparam int unsigned PMAX = (PM01 > PM23) ? PM01 : PM23;
  localparam int CW = (PMAX > 2) ? $clog2(PMAX) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  always_comb begin
    case (rate)
      2'd0:    reload = CW'(SMI_P0 - 1);
      2'd1:    reload = CW'(SMI_P1 - 1);
      2'd2:    reload = CW'(SMI_P2 - 1);
      default: reload = CW'(SMI_P3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rtc_rst) begin
      cnt      <= CW'(SMI_P0 - 1);
      smi_tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt      <= reload;
      smi_tick <= 1'b1;
    end else begin
      cnt      <= cnt - 1'b1;
      smi_tick <= 1'b0;
    end
  end

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rtc_rst)
    smi_tick |=> !smi_tick); // R1
endmodule

// File: rtl/pfm_wid_chk.sv
module pfm_wid_chk
  import pfm_pkg::*;
#(
  parameter int unsigned MINW_BASE = 32768
) (
  input  logic       clk,
  input  logic       rtc_rst,
  input  logic       rsm_rst,
  input  logic [2:0] pwr_state,
  input  logic       slp_deep,
  input  logic [1:0] minw,
  output logic       viol_set
);
  localparam int LW = $clog2(4 * MINW_BASE + 1);

  logic          slp_q;
  logic          rsm_q;
  logic          run;
  logic [LW-1:0] cnt;
  logic [LW-1:0] lim_m1;
  logic          deep_entry;
  logic          start;

  always_ff @(posedge clk) begin
    if (rtc_rst) begin
      slp_q <= 1'b0;
      rsm_q <= 1'b0;
    end else begin
      slp_q <= slp_deep;
      rsm_q <= rsm_rst;
    end
  end

  always_comb begin
    lim_m1     = LW'((32'(minw) + 32'd1) * 32'(MINW_BASE) - 32'd1);
    deep_entry = (pwr_state == PS_S4) || (pwr_state == PS_S5);
    start      = (slp_deep && !slp_q && deep_entry) || (rsm_q && !rsm_rst);
    viol_set   = run && !slp_deep;
  end

  always_ff @(posedge clk) begin
    if (rtc_rst || rsm_rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (!slp_deep || cnt == lim_m1) begin
        run <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (rtc_rst)
    (start && !rsm_rst) |=> run); // R6
  AST_WIDTH_MET: assert property (@(posedge clk) disable iff (rtc_rst)
    (run && slp_deep && cnt == lim_m1 && !start && !rsm_rst) |=> !run); // R7
endmodule

// File: rtl/pfm_regs.sv
module pfm_regs
  import pfm_pkg::*;
(
  input  logic             clk,
  input  logic             rtc_rst,
  input  logic             rsm_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pwr_set,
  input  logic             in_g3,
  input  logic             vrm_set,
  input  logic             viol_set,
  output cfg_t             cfg,
  output logic [REG_W-1:0] rd_data
);
  logic             pwr_flr;
  logic             vrm_flr;
  logic             viol;
  logic [REG_W-1:0] rd_n;
  logic             unused_rsv;

  assign unused_rsv = ^(wr_data & RSV_MASK);

  always_ff @(posedge clk) begin
    if (rtc_rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.rate    <= wr_data[F_RATE +: 2];
      cfg.pin_dis <= wr_data[F_PIN_DIS];
      cfg.stretch <= wr_data[F_STRETCH];
      cfg.minw    <= wr_data[F_MINW +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rtc_rst)                      pwr_flr <= 1'b0;
    else if (pwr_set)                 pwr_flr <= 1'b1;
    else if (in_g3)                   pwr_flr <= 1'b0;
    else if (wr_en && wr_data[F_PWR]) pwr_flr <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rtc_rst)                       vrm_flr <= 1'b0;
    else if (vrm_set)                  vrm_flr <= 1'b1;
    else if (wr_en && !wr_data[F_VRM]) vrm_flr <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rtc_rst || rsm_rst)            viol <= 1'b0;
    else if (viol_set)                 viol <= 1'b1;
    else if (wr_en && wr_data[F_VIOL]) viol <= 1'b0;
  end

  always_comb begin
    rd_n                 = '0;
    rd_n[F_RATE +: 2]    = cfg.rate;
    rd_n[F_PIN_DIS]      = cfg.pin_dis;
    rd_n[F_STRETCH]      = cfg.stretch;
    rd_n[F_MINW +: 2]    = cfg.minw;
    rd_n[F_PWR]          = pwr_flr;
    rd_n[F_VRM]          = vrm_flr;
    rd_n[F_VIOL]         = viol;
  end

  always_ff @(posedge clk) begin
    if (rtc_rst) rd_data <= '0;
    else         rd_data <= rd_n;
  end

  AST_PWR_SETS: assert property (@(posedge clk) disable iff (rtc_rst)
    pwr_set |=> pwr_flr); // R3
  AST_PWR_G3_CLEARS: assert property (@(posedge clk) disable iff (rtc_rst)
    in_g3 |=> !pwr_flr); // R4
  AST_VRM_HOLDS: assert property (@(posedge clk) disable iff (rtc_rst)
    (vrm_flr && !(wr_en && !wr_data[F_VRM])) |=> vrm_flr); // R5
  AST_CFG_SURVIVES_RSM: assert property (@(posedge clk) disable iff (rtc_rst)
    (rsm_rst && !wr_en) |=> $stable(cfg)); // R2
  AST_VIOL_RSM_CLEARS: assert property (@(posedge clk) disable iff (rtc_rst)
    rsm_rst |=> !viol); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rtc_rst)
    (rd_data & RSV_MASK) == '0); // R10
endmodule

// File: rtl/pwr_fail_monitor.sv
module pwr_fail_monitor
  import pfm_pkg::*;
#(
  parameter int unsigned SMI_P0    = 49,
  parameter int unsigned SMI_P1    = 524,
  parameter int unsigned SMI_P2    = 1049,
  parameter int unsigned SMI_P3    = 2097,
  parameter int unsigned MINW_BASE = 32768
) (
  input  logic        clk,
  input  logic        rtc_rst,
  input  logic        rsm_rst,
  input  logic [2:0]  pwr_state,
  input  logic        core_pg,
  input  logic        vrm_pg,
  input  logic        slp_deep,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        smi_tick,
  output logic        pin_out,
  output logic        pin_oe
);
  cfg_t cfg;
  logic pwr_set;
  logic vrm_set;
  logic in_g3;
  logic viol_set;

  pfm_pg_mon u_pg_mon (
    .clk       (clk),
    .rtc_rst   (rtc_rst),
    .pwr_state (pwr_state),
    .core_pg   (core_pg),
    .vrm_pg    (vrm_pg),
    .pwr_set   (pwr_set),
    .vrm_set   (vrm_set),
    .in_g3     (in_g3)
  );

  pfm_wid_chk #(.MINW_BASE(MINW_BASE)) u_wid_chk (
    .clk       (clk),
    .rtc_rst   (rtc_rst),
    .rsm_rst   (rsm_rst),
    .pwr_state (pwr_state),
    .slp_deep  (slp_deep),
    .minw      (cfg.minw),
    .viol_set  (viol_set)
  );

  pfm_smi_tmr #(
    .SMI_P0 (SMI_P0),
    .SMI_P1 (SMI_P1),
    .SMI_P2 (SMI_P2),
    .SMI_P3 (SMI_P3)
  ) u_smi_tmr (
    .clk      (clk),
    .rtc_rst  (rtc_rst),
    .rate     (cfg.rate),
    .smi_tick (smi_tick)
  );

  pfm_regs u_regs (
    .clk      (clk),
    .rtc_rst  (rtc_rst),
    .rsm_rst  (rsm_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pwr_set  (pwr_set),
    .in_g3    (in_g3),
    .vrm_set  (vrm_set),
    .viol_set (viol_set),
    .cfg      (cfg),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rtc_rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b1;
    end else begin
      pin_out <= slp_deep && !cfg.pin_dis;
      pin_oe  <= !cfg.pin_dis;
    end
  end

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (rtc_rst)
    cfg.pin_dis |=> (!pin_oe && !pin_out)); // R9
endmodule

// File: tb/pwr_fail_monitor_tb.sv
module pwr_fail_monitor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rtc_rst = 1'b1;
  logic        rsm_rst = 1'b0;
  logic [2:0]  pwr_state = 3'd0;
  logic        core_pg = 1'b1;
  logic        vrm_pg = 1'b1;
  logic        slp_deep = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        smi_tick;
  logic        pin_out;
  logic        pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_busy = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fail_monitor #(
    .SMI_P0(5), .SMI_P1(9), .SMI_P2(13), .SMI_P3(17), .MINW_BASE(4)
  ) u_dut (
    .clk(clk), .rtc_rst(rtc_rst), .rsm_rst(rsm_rst), .pwr_state(pwr_state),
    .core_pg(core_pg), .vrm_pg(vrm_pg), .slp_deep(slp_deep),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .smi_tick(smi_tick), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected register words and compares the read-back
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      repeat (2) @(negedge clk);
      begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, int'(rd_data), int'(e));
      end
      mon_busy = 1'b0;
    end
  end

  // Driver side of the scoreboard
  task automatic expect_reg(input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  task automatic write_reg(input logic [15:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    @(negedge clk);
  endtask

  task automatic pulse_core();
    core_pg = 1'b0;
    @(negedge clk);
    core_pg = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_vrm();
    vrm_pg = 1'b0;
    @(negedge clk);
    vrm_pg = 1'b1;
    @(negedge clk);
  endtask

  task automatic slp_hold(input int h);
    slp_deep = 1'b1;
    repeat (h) @(negedge clk);
    slp_deep = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick_gap(output int gap, output bit wide);
    int n;
    n = 0;
    while (!smi_tick && n < 100) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    wide = smi_tick;
    n = 1;
    while (!smi_tick && n < 100) begin
      @(negedge clk);
      n++;
    end
    gap = n;
  endtask

  task automatic check_rate(input logic [1:0] code, input int per, input string tag);
    int g;
    bit w;
    write_reg({14'd0, code});
    tick_gap(g, w);
    tick_gap(g, w);
    chk(g == per, tag, g, per);
    chk(!w, {tag, " pulse width"}, int'(w), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rtc_rst = 1'b0;
    @(negedge clk);
    expect_reg(16'h0000, "R10 reset value");
    chk(pin_oe == 1'b1, "R9 pin enabled after reset", int'(pin_oe), 1);

    // R9: pin follows deep-sleep one clock later
    slp_deep = 1'b1;
    @(negedge clk);
    chk(pin_out == 1'b1, "R9 pin follows high", int'(pin_out), 1);
    slp_deep = 1'b0;
    @(negedge clk);
    chk(pin_out == 1'b0, "R9 pin follows low", int'(pin_out), 0);

    // R10: reserved bits ignore writes
    write_reg(16'hFFFF);
    expect_reg(16'h003F, "R10 reserved bits read zero");
    write_reg(16'h0000);
    expect_reg(16'h0000, "R10 clear config");

    // R1: SMI interval per rate code
    check_rate(2'd0, 5, "R1 rate0");
    check_rate(2'd1, 9, "R1 rate1");
    check_rate(2'd2, 13, "R1 rate2");
    check_rate(2'd3, 17, "R1 rate3");
    write_reg(16'h0000);

    // R3 / R4: core power failure flag
    pwr_state = 3'd0;
    pulse_core();
    expect_reg(16'h0100, "R3 core fall in S0");
    write_reg(16'h0000);
    expect_reg(16'h0100, "R4 write 0 keeps core flag");
    write_reg(16'h0100);
    expect_reg(16'h0000, "R4 write 1 clears core flag");
    pwr_state = 3'd3;
    pulse_core();
    expect_reg(16'h0000, "R3 core fall in S3 ignored");
    pwr_state = 3'd1;
    pulse_core();
    expect_reg(16'h0100, "R3 core fall in S1");
    pwr_state = 3'd7;
    @(negedge clk);
    expect_reg(16'h0000, "R4 G3 clears core flag");
    pwr_state = 3'd0;
    @(negedge clk);

    // R5: regulator failure flag
    pulse_vrm();
    expect_reg(16'h0200, "R5 regulator fall in S0");
    write_reg(16'h0200);
    expect_reg(16'h0200, "R5 write 1 keeps regulator flag");
    write_reg(16'h0000);
    expect_reg(16'h0000, "R5 write 0 clears regulator flag");
    pwr_state = 3'd4;
    pulse_vrm();
    expect_reg(16'h0000, "R5 regulator fall in S4 ignored");

    // R7 / R8: minimum width checker, LIM = (code+1)*4
    slp_hold(4);
    expect_reg(16'h0400, "R7 width 4 of 4 violates");
    write_reg(16'h0400);
    expect_reg(16'h0000, "R8 write 1 clears violation");
    slp_hold(5);
    expect_reg(16'h0000, "R7 width 5 of 4 passes");
    write_reg(16'h0010);
    slp_hold(8);
    expect_reg(16'h0410, "R7 width 8 of 8 violates");
    write_reg(16'h0410);
    expect_reg(16'h0010, "R8 clear keeps config");
    slp_hold(9);
    expect_reg(16'h0010, "R7 width 9 of 8 passes");
    write_reg(16'h0008);
    expect_reg(16'h0008, "R7 stretch enabled");
    pwr_state = 3'd3;
    slp_hold(2);
    expect_reg(16'h0008, "R6 rise in S3 does not start");
    pwr_state = 3'd4;
    slp_hold(3);
    expect_reg(16'h0408, "R7 violation with stretch set");

    // R2 / R8 / R6: resume reset behaviour
    pwr_state = 3'd3;
    write_reg(16'h002F);
    expect_reg(16'h042F, "R2 config loaded");
    slp_deep = 1'b1;
    rsm_rst = 1'b1;
    @(negedge clk);
    expect_reg(16'h002F, "R8 R2 resume reset clears only violation");
    chk(pin_oe == 1'b0 && pin_out == 1'b0, "R9 pin released when disabled",
        int'({pin_oe, pin_out}), 0);
    rsm_rst = 1'b0;
    repeat (2) @(negedge clk);
    slp_deep = 1'b0;
    @(negedge clk);
    expect_reg(16'h042F, "R6 resume release starts timer");

    rtc_rst = 1'b1;
    repeat (3) @(negedge clk);
    rtc_rst = 1'b0;
    @(negedge clk);
    expect_reg(16'h0000, "R2 RTC reset clears config");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule